// File: doc/BRIEF.md
# Transient-Aware Cache Tag Controller

This block keeps the tags and line state of a small set-associative cache and decides, for every access, fill and incoming victim, where a line goes and which line leaves. Each line carries a transient attribute next to its valid and dirty bits. Accesses whose memory attribute or hint says the data will be used only briefly allocate their lines as transient. Transient lines are the first to be discarded when a set needs space. When one of them is pushed out, the outgoing eviction is flagged so that the level below does not allocate it.

Three streams feed one tag-update stage. The access port takes loads, stores and prefetches. The fill port takes line returns for earlier misses. The eviction input takes victims pushed down from the cache above, each with its own transient hint. A fill always wins that stage. An incoming victim waits on a ready/valid handshake. An access is accepted only when neither of the other two is present. Data storage, coherence and the lower memories are not modelled: only tags, state and routing decisions are.

Top module: `tnt_cache_ctl`

## Requirements
- R1: A synchronous active-low reset invalidates every way and clears all transient, dirty, replacement and pending-miss state. In the first cycle after reset, `rsp_valid` and `evo_valid` are 0 and the first access misses.
- R2: The access class is decoded from `acc_attr` (00 write-back, 01 write-back transient, 10 write-through, 11 non-cacheable) and `acc_op` (00 load, 01 store, 10 prefetch). An access is transient when the attribute is 01. It is also transient when the attribute is 00, the op is not a store and `acc_hint` is 1, which marks a non-temporal load or a streaming prefetch. For stores and for attribute 10, `acc_hint` has no effect.
- R3: A cacheable access that misses records one pending miss: its line address, its transient class, and whether it was a store. A later fill whose address equals the pending address installs the line with that transient class and is dirty if the miss was a store, and the pending miss is then retired. Any other fill installs a clean, non-transient line.
- R4: Every accepted access produces `rsp_valid` = 1 exactly one cycle later, with `rsp_hit` set when a valid way of the indexed set holds the tag.
- R5: A hit by a non-transient access clears that line's transient bit. A hit by a transient access leaves the bit unchanged.
- R6: When a set needs a way, the victim is the lowest-index invalid way. If there is none, it is the lowest-index transient way. Otherwise it is the way chosen by the pseudo-LRU tree.
- R7: The pseudo-LRU tree keeps WAYS-1 bits per set, all 0 after reset. At node n (the root is 1), bit 0 leads to child 2n (the lower half) and bit 1 leads to child 2n+1. Leaf WAYS+w is way w. Every hit and every install sets the bits on the way's path to point away from it.
- R8: An install that replaces a valid line gives, one cycle later, a one-cycle `evo_valid` pulse. This pulse carries the victim's line address (its tag above the set index), its dirty bit, and `evo_bypass` equal to its transient bit. When `evo_valid` is 0, `evo_dirty` and `evo_bypass` are 0.
- R9: An incoming victim installs its line with the transient bit equal to `evi_hint` and the dirty bit equal to `evi_dirty`. If the line is already present, it is updated in place: the transient bit is set to `evi_hint`, the dirty bit becomes its old value ORed with `evi_dirty`, and nothing is evicted.
- R10: The priority of the update stage is fill, then incoming victim, then access. `evi_ready` is 0 while `fill_valid` is 1. `acc_ready` is 0 while `fill_valid` or `evi_valid` is 1.
- R11: A non-cacheable access (attribute 11) reports `rsp_hit` = 0 and changes no line, replacement or pending-miss state, even when the line is present.
- R12: A store hit sets the line's dirty bit, and that bit is reported when the line is later evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_addr | input | LA_W | Access line address |
| acc_op | input | 2 | 00 load, 01 store, 10 prefetch |
| acc_attr | input | 2 | Memory attribute of the access |
| acc_hint | input | 1 | Non-temporal load or streaming prefetch |
| rsp_valid | output | 1 | Access response |
| rsp_hit | output | 1 | Access hit |
| fill_valid | input | 1 | Line return present |
| fill_addr | input | LA_W | Line return address |
| evi_valid | input | 1 | Victim from the level above present |
| evi_ready | output | 1 | Victim accepted this cycle |
| evi_addr | input | LA_W | Incoming victim line address |
| evi_dirty | input | 1 | Incoming victim is dirty |
| evi_hint | input | 1 | Incoming victim carries the transient hint |
| evo_valid | output | 1 | Eviction toward the next level |
| evo_addr | output | LA_W | Evicted line address |
| evo_dirty | output | 1 | Evicted line is dirty |
| evo_bypass | output | 1 | Evicted line must skip the next level |

## Verification
The bench fills one set with a mix of lines: one ordinary, one transient by attribute, one transient by a non-temporal load and one transient by a streaming prefetch. It then forces a replacement. A design that ranked transient lines below the pseudo-LRU choice would evict the ordinary line, and one that dropped the hint on eviction would send it out with `evo_bypass` low. A store that carries the hint, and a reuse hit by an ordinary load, check that neither leaves a line transient; a wrong design would later evict that line with the bypass flag set. It also drives a fill, an incoming victim and an access in the same cycle, re-installs a line that is already present, and looks up a present line as non-cacheable. Wrong priority, a spurious eviction, or a hit on uncached memory would each appear at the response or eviction ports.

// File: rtl/tnt_pkg.sv
// Shared encodings for the transient-aware cache tag controller.
// Assumes the attribute and op fields are two bits wide each.
package tnt_pkg;

    typedef enum logic [1:0] {
        ATTR_WB       = 2'b00,
        ATTR_WB_SHORT = 2'b01,
        ATTR_WT       = 2'b10,
        ATTR_NC       = 2'b11
    } mem_attr_e;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'b00,
        OP_STORE    = 2'b01,
        OP_PREFETCH = 2'b10
    } acc_op_e;

endpackage

// File: rtl/tnt_class_decode.sv
// Decodes the class of an access: cacheable, store, transient.
// Assumes the hint only means something for loads and prefetches to write-back memory.
module tnt_class_decode
    import tnt_pkg::*;
(
    input  logic [1:0] attr,
    input  logic [1:0] op,
    input  logic       hint,
    output logic       cacheable,
    output logic       is_store,
    output logic       transient
);

    // Pure decode of attribute, op and hint (R2)
    always_comb begin
        is_store  = (op == OP_STORE);
        cacheable = (attr != ATTR_NC);
        transient = (attr == ATTR_WB_SHORT) ||
                    ((attr == ATTR_WB) && hint && !is_store);
    end

endmodule

// File: rtl/tnt_tag_match.sv
// Compares one tag against every way of a set and encodes the hitting way.
// Assumes at most one valid way holds a given tag.
module tnt_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int LOG_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [TAG_W-1:0] tags [WAYS],
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [LOG_W-1:0] hit_way
);

    logic [WAYS-1:0] hit_vec;

    // One comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w] == tag);
    end

    // Encode the hitting way
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = LOG_W'(w);
        end
    end

endmodule

// File: rtl/tnt_victim_sel.sv
// Picks the way to replace: invalid first, then lowest transient, then pseudo-LRU.
// Assumes WAYS is a power of two and at least two.
module tnt_victim_sel #(
    parameter int WAYS = 4,
    localparam int LOG_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  trans,
    input  logic [WAYS-2:0]  plru,
    output logic [LOG_W-1:0] way
);

    // Ordered search over the three victim classes (R6)
    always_comb begin
        logic found;
        int   node;
        found = 1'b0;
        way   = '0;
        node  = 1;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid[w]) begin
                way   = LOG_W'(w);
                found = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && trans[w]) begin
                way   = LOG_W'(w);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int l = 0; l < LOG_W; l++) begin
                node = node * 2 + int'(plru[node-1]);
            end
            way = LOG_W'(node - WAYS);
        end
    end

endmodule

// File: rtl/tnt_plru_update.sv
// Computes the pseudo-LRU tree after a way is touched.
// Assumes the heap layout: root is node 1, leaf WAYS+w is way w.
module tnt_plru_update #(
    parameter int WAYS = 4,
    localparam int LOG_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  cur,
    input  logic [LOG_W-1:0] way,
    output logic [WAYS-2:0]  nxt
);

    // Walk from the leaf to the root, pointing every node away (R7)
    always_comb begin
        int node;
        int parent;
        nxt  = cur;
        node = int'(way) + WAYS;
        for (int l = 0; l < LOG_W; l++) begin
            parent        = node / 2;
            nxt[parent-1] = (node % 2 == 0);
            node          = parent;
        end
    end

endmodule

// File: rtl/tnt_cache_ctl.sv
// Tag and state controller of a set-associative cache with per-line transient attribute.
// One update stage is shared by fills, incoming victims and accesses (fill first).
// Assumes SETS and WAYS are powers of two, each at least two; one miss is tracked at a time.
module tnt_cache_ctl #(
    parameter int LA_W = 12,
    parameter int WAYS = 4,
    parameter int SETS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    output logic            acc_ready,
    input  logic [LA_W-1:0] acc_addr,
    input  logic [1:0]      acc_op,
    input  logic [1:0]      acc_attr,
    input  logic            acc_hint,
    output logic            rsp_valid,
    output logic            rsp_hit,
    input  logic            fill_valid,
    input  logic [LA_W-1:0] fill_addr,
    input  logic            evi_valid,
    output logic            evi_ready,
    input  logic [LA_W-1:0] evi_addr,
    input  logic            evi_dirty,
    input  logic            evi_hint,
    output logic            evo_valid,
    output logic [LA_W-1:0] evo_addr,
    output logic            evo_dirty,
    output logic            evo_bypass
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LA_W - IDX_W;
    localparam int LOG_W = $clog2(WAYS);

    // Line state
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  trans_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAYS-2:0]  plru_q  [SETS];

    // Pending miss
    logic             pend_valid_q;
    logic [LA_W-1:0]  pend_addr_q;
    logic             pend_trans_q;
    logic             pend_store_q;

    // Registered outputs
    logic             rsp_valid_q, rsp_hit_q;
    logic             evo_valid_q, evo_dirty_q, evo_bypass_q;
    logic [LA_W-1:0]  evo_addr_q;

    logic             fill_go, evi_go, acc_go, ins_go;
    logic [LA_W-1:0]  lk_addr;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [TAG_W-1:0] set_tags [WAYS];
    logic [WAYS-1:0]  set_valid, set_trans, set_dirty;
    logic [WAYS-2:0]  set_plru, plru_nxt;
    logic             lk_hit;
    logic [LOG_W-1:0] hit_way, vic_way, tgt_way;
    logic             acc_cacheable, acc_store, acc_transient;
    logic             pend_match, ins_trans, ins_dirty, ins_evicts;

    // Arbitration of the shared update stage (R10)
    always_comb begin
        fill_go   = fill_valid;
        evi_go    = evi_valid && !fill_valid;
        acc_go    = acc_valid && !fill_valid && !evi_valid;
        ins_go    = fill_go || evi_go;
        evi_ready = !fill_valid;
        acc_ready = !fill_valid && !evi_valid;
    end

    // Select the lookup address and read out the indexed set
    always_comb begin
        lk_addr   = fill_go ? fill_addr : (evi_go ? evi_addr : acc_addr);
        lk_idx    = lk_addr[IDX_W-1:0];
        lk_tag    = lk_addr[LA_W-1:IDX_W];
        set_valid = valid_q[lk_idx];
        set_trans = trans_q[lk_idx];
        set_dirty = dirty_q[lk_idx];
        set_plru  = plru_q[lk_idx];
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[lk_idx][w];
    end

    tnt_class_decode u_class (
        .attr      (acc_attr),
        .op        (acc_op),
        .hint      (acc_hint),
        .cacheable (acc_cacheable),
        .is_store  (acc_store),
        .transient (acc_transient)
    );

    tnt_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid   (set_valid),
        .tags    (set_tags),
        .tag     (lk_tag),
        .hit     (lk_hit),
        .hit_way (hit_way)
    );

    tnt_victim_sel #(.WAYS(WAYS)) u_victim (
        .valid (set_valid),
        .trans (set_trans),
        .plru  (set_plru),
        .way   (vic_way)
    );

    tnt_plru_update #(.WAYS(WAYS)) u_plru (
        .cur (set_plru),
        .way (tgt_way),
        .nxt (plru_nxt)
    );

    // Values written by an install and the eviction it causes (R3, R9)
    always_comb begin
        tgt_way    = lk_hit ? hit_way : vic_way;
        pend_match = pend_valid_q && (pend_addr_q == fill_addr);
        ins_trans  = fill_go ? (pend_match && pend_trans_q) : evi_hint;
        ins_dirty  = fill_go ? (pend_match && pend_store_q) : evi_dirty;
        ins_evicts = ins_go && !lk_hit && set_valid[vic_way];
    end

    // State and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                trans_q[s] <= '0;
                dirty_q[s] <= '0;
                plru_q[s]  <= '0;
            end
            pend_valid_q <= 1'b0;
            pend_addr_q  <= '0;
            pend_trans_q <= 1'b0;
            pend_store_q <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_hit_q    <= 1'b0;
            evo_valid_q  <= 1'b0;
            evo_addr_q   <= '0;
            evo_dirty_q  <= 1'b0;
            evo_bypass_q <= 1'b0;
        end else begin
            rsp_valid_q  <= acc_go;
            rsp_hit_q    <= acc_go && acc_cacheable && lk_hit;
            evo_valid_q  <= ins_evicts;
            evo_addr_q   <= {set_tags[vic_way], lk_idx};
            evo_dirty_q  <= ins_evicts && set_dirty[vic_way];
            evo_bypass_q <= ins_evicts && set_trans[vic_way];
            if (ins_go) begin
                tag_q[lk_idx][tgt_way]   <= lk_tag;
                valid_q[lk_idx][tgt_way] <= 1'b1;
                trans_q[lk_idx][tgt_way] <= ins_trans;
                dirty_q[lk_idx][tgt_way] <= ins_dirty || (lk_hit && set_dirty[tgt_way]);
                plru_q[lk_idx]           <= plru_nxt;
            end
            if (fill_go && pend_match) pend_valid_q <= 1'b0;
            if (acc_go && acc_cacheable) begin
                if (lk_hit) begin
                    plru_q[lk_idx] <= plru_nxt;
                    if (!acc_transient) trans_q[lk_idx][tgt_way] <= 1'b0;
                    if (acc_store) dirty_q[lk_idx][tgt_way] <= 1'b1;
                end else begin
                    pend_valid_q <= 1'b1;
                    pend_addr_q  <= acc_addr;
                    pend_trans_q <= acc_transient;
                    pend_store_q <= acc_store;
                end
            end
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_hit    = rsp_hit_q;
    assign evo_valid  = evo_valid_q;
    assign evo_addr   = evo_addr_q;
    assign evo_dirty  = evo_dirty_q;
    assign evo_bypass = evo_bypass_q;

endmodule

// File: rtl/tnt_cache_ctl_chk.sv
// Port-level properties of the transient-aware cache tag controller.
// Assumes WAYS + 1 fits in the 8-bit install counter.
module tnt_cache_ctl_chk #(
    parameter int LA_W = 12,
    parameter int WAYS = 4,
    parameter int SETS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            acc_ready,
    input logic [1:0]      acc_attr,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            fill_valid,
    input logic            evi_valid,
    input logic            evi_ready,
    input logic            evo_valid,
    input logic            evo_dirty,
    input logic            evo_bypass
);

    logic [7:0] ins_cnt;

    // Count installs since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) ins_cnt <= '0;
        else if ((fill_valid || (evi_valid && evi_ready)) && ins_cnt != 8'hff)
            ins_cnt <= ins_cnt + 8'd1;
    end

    // R4
    acc_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> rsp_valid);

    // R4
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_ready) |=> !rsp_valid);

    // R1
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R11
    nc_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_attr == 2'b11) |=> !rsp_hit);

    // R10
    fill_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (!acc_ready && !evi_ready));

    // R8
    evo_from_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evo_valid |-> $past(fill_valid || (evi_valid && evi_ready)));

    // R8
    evo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evo_valid |-> (!evo_dirty && !evo_bypass));

    // R6
    evo_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evo_valid |-> (ins_cnt > 8'(WAYS)));

endmodule

bind tnt_cache_ctl tnt_cache_ctl_chk #(.LA_W(LA_W), .WAYS(WAYS), .SETS(SETS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_attr   (acc_attr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .fill_valid (fill_valid),
    .evi_valid  (evi_valid),
    .evi_ready  (evi_ready),
    .evo_valid  (evo_valid),
    .evo_dirty  (evo_dirty),
    .evo_bypass (evo_bypass)
);

// File: tb/tnt_cache_ctl_tb.sv
// Bench for tnt_cache_ctl: directed corner cases, then seeded random traffic,
// all checked against a behavioural model written from the requirements.
module tnt_cache_ctl_tb_top;

    localparam int CLK_P = 10;
    localparam int LA_W  = 12;
    localparam int WAYS  = 4;
    localparam int SETS  = 4;
    localparam int IDX_W = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            acc_valid, acc_ready, acc_hint;
    logic [LA_W-1:0] acc_addr;
    logic [1:0]      acc_op, acc_attr;
    logic            rsp_valid, rsp_hit;
    logic            fill_valid;
    logic [LA_W-1:0] fill_addr;
    logic            evi_valid, evi_ready, evi_dirty, evi_hint;
    logic [LA_W-1:0] evi_addr;
    logic            evo_valid, evo_dirty, evo_bypass;
    logic [LA_W-1:0] evo_addr;

    int checks = 0;
    int fails  = 0;

    // Model state
    bit        m_valid [SETS][WAYS];
    bit        m_trans [SETS][WAYS];
    bit        m_dirty [SETS][WAYS];
    int        m_tag   [SETS][WAYS];
    bit [WAYS-2:0] m_plru [SETS];
    bit        m_pv, m_pt, m_ps;
    int        m_pa;

    always #(CLK_P/2) clk = ~clk;

    tnt_cache_ctl #(.LA_W(LA_W), .WAYS(WAYS), .SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
        .acc_op(acc_op), .acc_attr(acc_attr), .acc_hint(acc_hint),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .evi_valid(evi_valid), .evi_ready(evi_ready), .evi_addr(evi_addr),
        .evi_dirty(evi_dirty), .evi_hint(evi_hint),
        .evo_valid(evo_valid), .evo_addr(evo_addr),
        .evo_dirty(evo_dirty), .evo_bypass(evo_bypass)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_victim(int s);
        int node;
        for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
        for (int w = 0; w < WAYS; w++) if (m_trans[s][w]) return w;
        node = 1;
        for (int l = 0; l < IDX_W; l++) node = node * 2 + int'(m_plru[s][node-1]);
        return node - WAYS;
    endfunction

    task automatic m_touch(int s, int w);
        int node;
        node = w + WAYS;
        while (node > 1) begin
            m_plru[s][node/2 - 1] = (node % 2 == 0);
            node = node / 2;
        end
    endtask

    function automatic int m_find(int s, int t);
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic m_reset();
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_trans[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0;
            end
            m_plru[s] = '0;
        end
        m_pv = 0; m_pt = 0; m_ps = 0; m_pa = 0;
    endtask

    // One cycle of stimulus, model update and output check
    task automatic step(bit fv, int fa, bit ev, int ea, bit ed, bit eh,
                        bit av, int aa, int aop, int aattr, bit ah, string tag);
        bit e_rv, e_rh, e_ev, e_ed, e_eb;
        int e_ea;
        bit ins, itr, idr, cach, st, tr;
        int iaddr, s, t, w;
        @(negedge clk);
        fill_valid = fv; fill_addr = LA_W'(fa);
        evi_valid = ev; evi_addr = LA_W'(ea); evi_dirty = ed; evi_hint = eh;
        acc_valid = av; acc_addr = LA_W'(aa); acc_op = 2'(aop); acc_attr = 2'(aattr); acc_hint = ah;
        #1;
        chk(tag, "R10 evi_ready", int'(evi_ready), int'(!fv));
        chk(tag, "R10 acc_ready", int'(acc_ready), int'(!fv && !ev));
        e_rv = 0; e_rh = 0; e_ev = 0; e_ea = 0; e_ed = 0; e_eb = 0;
        ins = 0; itr = 0; idr = 0; iaddr = 0;
        if (fv) begin
            ins = 1; iaddr = fa;
            if (m_pv && m_pa == fa) begin itr = m_pt; idr = m_ps; m_pv = 0; end
        end else if (ev) begin
            ins = 1; iaddr = ea; itr = eh; idr = ed;
        end else if (av) begin
            e_rv = 1;
            cach = (aattr != 3); st = (aop == 1);
            tr = (aattr == 1) || (aattr == 0 && ah && !st);
            s = aa % SETS; t = aa / SETS; w = m_find(s, t);
            if (cach) begin
                if (w >= 0) begin
                    e_rh = 1; m_touch(s, w);
                    if (!tr) m_trans[s][w] = 0;
                    if (st) m_dirty[s][w] = 1;
                end else begin
                    m_pv = 1; m_pa = aa; m_pt = tr; m_ps = st;
                end
            end
        end
        if (ins) begin
            s = iaddr % SETS; t = iaddr / SETS; w = m_find(s, t);
            if (w >= 0) begin
                m_trans[s][w] = itr; m_dirty[s][w] = m_dirty[s][w] | idr;
            end else begin
                w = m_victim(s);
                if (m_valid[s][w]) begin
                    e_ev = 1; e_ea = m_tag[s][w] * SETS + s;
                    e_ed = m_dirty[s][w]; e_eb = m_trans[s][w];
                end
                m_valid[s][w] = 1; m_tag[s][w] = t; m_trans[s][w] = itr; m_dirty[s][w] = idr;
            end
            m_touch(s, w);
        end
        @(posedge clk);
        #1;
        chk(tag, "R4 rsp_valid", int'(rsp_valid), int'(e_rv));
        chk(tag, "R4 rsp_hit", int'(rsp_hit), int'(e_rh));
        chk(tag, "R8 evo_valid", int'(evo_valid), int'(e_ev));
        chk(tag, "R8 evo_dirty", int'(evo_dirty), int'(e_ed));
        chk(tag, "R8 evo_bypass", int'(evo_bypass), int'(e_eb));
        if (e_ev) chk(tag, "R8 evo_addr", int'(evo_addr), e_ea);
    endtask

    task automatic acc(int a, int op, int attr, bit h, string tag);
        step(0, 0, 0, 0, 0, 0, 1, a, op, attr, h, tag);
    endtask
    task automatic fill(int a, string tag);
        step(1, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic evin(int a, bit d, bit h, string tag);
        step(0, 0, 1, a, d, h, 0, 0, 0, 0, 0, tag);
    endtask

    // Watchdog: a hung run is one failed check
    initial begin
        #(CLK_P * 200000);
        checks++; fails++;
        $display("FAIL R1 watchdog act=1 exp=0");
        summary();
        $finish;
    end

    initial begin
        int fa, ea, aa, r;
        void'($urandom(32'h1d5a));
        rst_n = 1'b0;
        fill_valid = 0; fill_addr = '0; evi_valid = 0; evi_addr = '0;
        evi_dirty = 0; evi_hint = 0; acc_valid = 0; acc_addr = '0;
        acc_op = '0; acc_attr = '0; acc_hint = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset, first access misses
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        acc(1*4, 0, 0, 0, "R1");
        // R3: normal miss then fill, transient-attribute miss then fill
        fill(1*4, "R3");
        acc(2*4, 0, 1, 0, "R3");
        fill(2*4, "R3");
        // R2: non-temporal load and streaming prefetch become transient
        acc(3*4, 0, 0, 1, "R2");
        fill(3*4, "R2");
        acc(4*4, 2, 0, 1, "R2");
        fill(4*4, "R2");
        // R6: store with hint is not transient; victim is lowest transient way (tag 2)
        acc(5*4, 1, 0, 1, "R2");
        fill(5*4, "R6");
        chk("R6", "victim addr", int'(evo_addr), 2*4);
        chk("R6", "victim bypass", int'(evo_bypass), 1);
        // R5: normal hit clears transient on tag 3; tag 4 goes next
        acc(3*4, 0, 0, 0, "R5");
        acc(6*4, 0, 2, 1, "R2");
        fill(6*4, "R5");
        chk("R5", "victim addr", int'(evo_addr), 4*4);
        // R7: all lines ordinary, pseudo-LRU picks the victim
        evin(7*4, 1, 0, "R7");
        chk("R7", "plru eviction bypass", int'(evo_bypass), 0);
        // R9: victim with hint installs transient; in-place update on re-entry
        evin(8*4, 0, 1, "R9");
        evin(8*4, 1, 0, "R9");
        chk("R9", "no eviction on present line", int'(evo_valid), 0);
        // R11: non-cacheable lookup of a present line misses
        acc(8*4, 0, 3, 0, "R11");
        acc(8*4, 0, 0, 0, "R11");
        // R12: store hit marks dirty, seen when evicted later
        acc(1*4 + 1, 0, 0, 0, "R12");
        fill(1*4 + 1, "R12");
        acc(1*4 + 1, 1, 0, 0, "R12");
        for (int k = 2; k < 7; k++) evin(k*4 + 1, 0, 0, "R12");
        // R10: all three streams in one cycle, then the victim alone
        step(1, 9*4, 1, 10*4, 0, 1, 1, 8*4, 0, 0, 0, "R10");
        step(0, 0, 1, 10*4, 0, 1, 1, 8*4, 0, 0, 0, "R10");
        acc(10*4, 0, 0, 0, "R10");

        // Seeded random traffic over a small address pool
        for (int i = 0; i < 4000; i++) begin
            r  = int'($urandom_range(0, 99));
            aa = int'($urandom_range(0, 23));
            ea = int'($urandom_range(0, 23));
            fa = (m_pv && $urandom_range(0, 3) != 0) ? m_pa : int'($urandom_range(0, 23));
            step(r < 20, fa, (r >= 15 && r < 35), ea, 1'($urandom), 1'($urandom),
                 r >= 30, aa, int'($urandom_range(0, 2)), int'($urandom_range(0, 3)),
                 1'($urandom), "R4/R8 random");
        end

        summary();
        $finish;
    end

endmodule